// File: doc/BRIEF.md
# Linked-List Summing Engine

This block walks a singly linked list held in a single-ported memory and adds up the signed values stored in its nodes. Each node occupies two consecutive bytes: the pointer to the following node sits at the node's base address, and an 8-bit two's-complement value sits one byte above it. The walk always begins at address 0. A node whose pointer is zero is the last one. The list always holds at least one node. The memory is outside the block. The engine presents an address and reads the data combinationally in the same cycle.

A one-cycle pulse on `start` clears the running total and begins a walk from the head. Each node takes exactly two cycles. In the accumulate state, the engine reads the value at the precomputed value address and adds it, sign-extended, to a 16-bit total. In the fetch state, it reads the pointer, loads it as the next node address, and in the same cycle loads pointer + 1 as the next value address. Precomputing that address keeps the two states' paths balanced, so one adder can be shared between the increment and the accumulation. A zero pointer sends the engine to the finished state. There it raises `done` and shows the total on `result` until the next `start`.

States are IDLE (after reset), ACCUM (compute-sum), FETCH (get-next) and FIN (done). The transitions are: any state to ACCUM on `start`; ACCUM to FETCH; FETCH to ACCUM on a nonzero pointer; FETCH to FIN on a zero pointer. IDLE and FIN hold while `start` is low.

Top module: `list_sum_engine`

## Requirements
- R1: After reset, `done` is 0 and `result` is 0. The engine stays idle and ignores memory data until `start` is asserted.
- R2: `start` clears the total and the node address and sets the value address to 1. In the first cycle after `start`, `mem_addr` is 1.
- R3: In the accumulate cycle, `mem_addr` equals the value address, and the byte read is added, sign-extended, to the total.
- R4: In the fetch cycle, `mem_addr` equals the current node address (the base, offset 0). The byte read becomes the next node address, and that byte + 1 (modulo 256) becomes the next value address.
- R5: Accumulate and fetch alternate, so every node costs exactly two cycles. `done` rises exactly 2·N clock edges after the edge that samples `start`, for an N-node list.
- R6: When the fetched pointer is 0, the engine enters the finished state. `done` is then 1, and `result` equals the sum of all node values.
- R7: In the finished state, `done` stays 1 and `result` stays unchanged while `start` is low. Outside the finished state, `done` is 0 and `result` is 0.
- R8: `start` asserted in any state, including mid-walk, abandons the current walk and restarts from the head with a cleared total.
- R9: Values are signed. Negative bytes (0x80..0xFF) subtract from the total. The 16-bit total holds any list of up to 128 nodes without overflow, from -16384 to +16256.
- R10: A list whose head pointer (address 0) is 0 yields the single value at address 1 after exactly 2 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a new walk from the list head |
| mem_rdata | input | 8 | Combinational read data from the list memory |
| mem_addr | output | 8 | Address presented to the list memory |
| done | output | 1 | High while the finished total is valid |
| result | output | 16 | Signed sum of node values, valid when `done` is 1 |

## Verification
Several properties are checked on every cycle: accumulate is always followed by fetch, the restart values are loaded after `start`, the value address is always one above the freshly loaded node address, a zero pointer always leads to the finished state, and `done` and `result` hold while finished. Only the bench's scenarios can show that the total is arithmetically right. Those scenarios cover single-node lists, negative values, scattered and full 128-node lists, the exact cycle count per node, and correct recovery when a walk is restarted mid-list.

// File: rtl/lse_pkg.sv
package lse_pkg;
    localparam int unsigned PTR_W = 8;
    localparam int unsigned SUM_W = 16;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ACCUM = 2'd1,
        ST_FETCH = 2'd2,
        ST_FIN   = 2'd3
    } lse_state_e;

    typedef struct packed {
        logic init;     // load restart values
        logic ld_total; // load accumulator
        logic ld_link;  // load node and value address registers
        logic addr_sel; // 0: value address, 1: node address
        logic add_sel;  // 0: total + data, 1: data + 1
        logic fin;      // finished flag
    } lse_ctl_t;
endpackage

// File: rtl/lse_ctrl.sv
module lse_ctrl
    import lse_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     start,
    input  logic     ptr_zero,
    output lse_ctl_t ctl
);
    lse_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        if (start) begin
            state_d = ST_ACCUM;
        end else begin
            unique case (state_q)
                ST_IDLE:  state_d = ST_IDLE;
                ST_ACCUM: state_d = ST_FETCH;
                ST_FETCH: state_d = ptr_zero ? ST_FIN : ST_ACCUM;
                ST_FIN:   state_d = ST_FIN;
                default:  state_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        ctl = '0;
        ctl.init = start;
        unique case (state_q)
            ST_IDLE: ;
            ST_ACCUM: begin
                ctl.ld_total = !start;
                ctl.addr_sel = 1'b0;
                ctl.add_sel  = 1'b0;
            end
            ST_FETCH: begin
                ctl.ld_link  = !start;
                ctl.addr_sel = 1'b1;
                ctl.add_sel  = 1'b1;
            end
            ST_FIN: ctl.fin = 1'b1;
            default: ;
        endcase
    end

    // R5: accumulate is always followed by fetch
    p_accum_then_fetch_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ACCUM && !start) |=> (state_q == ST_FETCH));
    // R8: start from any state restarts the walk
    p_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (state_q == ST_ACCUM));
    // R6: a zero pointer in fetch ends the walk
    p_zero_ends_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FETCH && ptr_zero && !start) |=> (state_q == ST_FIN));
    // R7: the finished state holds until start
    p_fin_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FIN && !start) |=> (state_q == ST_FIN));
endmodule

// File: rtl/lse_datapath.sv
module lse_datapath
    import lse_pkg::*;
#(
    parameter int unsigned PW = PTR_W,
    parameter int unsigned SW = SUM_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  lse_ctl_t      ctl,
    input  logic [PW-1:0] mem_rdata,
    output logic [PW-1:0] mem_addr,
    output logic          ptr_zero,
    output logic [SW-1:0] result
);
    localparam int unsigned EXT_W = SW - PW;

    logic [PW-1:0] node_q;   // current node base address
    logic [PW-1:0] vaddr_q;  // precomputed value address
    logic [SW-1:0] total_q;

    logic [SW-1:0] opnd_a, opnd_b, add_out;

    // shared adder: total + sext(data) in accumulate, data + 1 in fetch
    always_comb begin
        if (ctl.add_sel) begin
            opnd_a = {{EXT_W{1'b0}}, mem_rdata};
            opnd_b = {{(SW-1){1'b0}}, 1'b1};
        end else begin
            opnd_a = total_q;
            opnd_b = {{EXT_W{mem_rdata[PW-1]}}, mem_rdata};
        end
        add_out = opnd_a + opnd_b;
    end

    assign mem_addr = ctl.addr_sel ? node_q : vaddr_q;
    assign ptr_zero = (mem_rdata == '0);
    assign result   = ctl.fin ? total_q : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            node_q  <= '0;
            vaddr_q <= PW'(1);
            total_q <= '0;
        end else if (ctl.init) begin
            node_q  <= '0;
            vaddr_q <= PW'(1);
            total_q <= '0;
        end else begin
            if (ctl.ld_total) total_q <= add_out;
            if (ctl.ld_link) begin
                node_q  <= mem_rdata;
                vaddr_q <= add_out[PW-1:0];
            end
        end
    end

    // R2: restart values loaded after start
    p_restart_vals_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.init |=> (total_q == '0 && node_q == '0 && vaddr_q == PW'(1)));
    // R4: value address sits one above the freshly loaded node address
    p_link_pair_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl.ld_link && !ctl.init) |=> (vaddr_q == PW'(node_q + PW'(1))));
    // R7: result frozen while finished
    p_result_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl.fin && !ctl.init) |=> $stable(result));
    // R3: total only moves on accumulate cycles
    p_total_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl.ld_total && !ctl.init) |=> $stable(total_q));
endmodule

// File: rtl/list_sum_engine.sv
module list_sum_engine
    import lse_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [PTR_W-1:0]     mem_rdata,
    output logic [PTR_W-1:0]     mem_addr,
    output logic                 done,
    output logic [SUM_W-1:0]     result
);
    lse_ctl_t ctl;
    logic     ptr_zero;

    lse_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .ptr_zero (ptr_zero),
        .ctl      (ctl)
    );

    lse_datapath #(.PW(PTR_W), .SW(SUM_W)) u_dp (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl       (ctl),
        .mem_rdata (mem_rdata),
        .mem_addr  (mem_addr),
        .ptr_zero  (ptr_zero),
        .result    (result)
    );

    assign done = ctl.fin;

    // R7: done stays high until start
    p_done_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done);
    // R1: no finish without a walk after reset
    p_no_spurious_done_r1: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !done);
endmodule

// File: tb/sim_list_sum_engine.sv
module sim_list_sum_engine;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  mem_rdata;
    logic [7:0]  mem_addr;
    logic        done;
    logic [15:0] result;

    logic [7:0] mem [256];
    int total_checks = 0;
    int bad_checks = 0;
    int exp_sum;
    int bases [128];
    bit finished = 0;

    always #4 clk = ~clk;   // 125 MHz

    assign mem_rdata = mem[mem_addr];

    list_sum_engine u0 (
        .clk(clk), .rst_n(rst_n), .start(start),
        .mem_rdata(mem_rdata), .mem_addr(mem_addr),
        .done(done), .result(result)
    );

    task automatic check(input string req, input int act, input int exp);
        total_checks++;
        if (act != exp) begin
            bad_checks++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Fill memory with junk, then lay out n nodes; vals_mode 0 random, 1 all -128, 2 all 127
    task automatic build(input int n, input int vals_mode);
        int slots [127];
        for (int i = 0; i < 256; i++) mem[i] = 8'($urandom);
        for (int i = 0; i < 127; i++) slots[i] = 2 * (i + 1);
        for (int i = 126; i > 0; i--) begin
            int j = int'($urandom % (i + 1));
            int t = slots[i];
            slots[i] = slots[j];
            slots[j] = t;
        end
        bases[0] = 0;
        for (int i = 1; i < n; i++) bases[i] = slots[i-1];
        exp_sum = 0;
        for (int i = 0; i < n; i++) begin
            logic [7:0] v;
            v = (vals_mode == 1) ? 8'h80 : (vals_mode == 2) ? 8'h7F : 8'($urandom);
            mem[bases[i]]     = (i == n - 1) ? 8'h00 : 8'(bases[i+1]);
            mem[bases[i] + 1] = v;
            exp_sum += int'($signed(v));
        end
    endtask

    // Pulse start, wait for done, check cycle count and sum
    task automatic run_and_check(input string req, input int n);
        int cyc = 0;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        while (!done && cyc < 1000) begin
            @(negedge clk);
            cyc++;
        end
        check({req, " cycles"}, cyc, 2 * n);
        check({req, " sum"}, int'($signed(result)), exp_sum);
    endtask

    task automatic t_reset;
        check("R1 done at reset", int'(done), 0);
        check("R1 result at reset", int'(result), 0);
        repeat (3) @(negedge clk);
        check("R1 idle ignores data", int'(done), 0);
    endtask

    task automatic t_single;
        build(1, 0);
        mem[1] = 8'hFB;
        exp_sum = -5;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        check("R2 first addr", int'(mem_addr), 1);
        @(negedge clk);
        check("R4 fetch addr is base", int'(mem_addr), 0);
        @(negedge clk);
        check("R10 single node done", int'(done), 1);
        check("R10 single node sum", int'($signed(result)), -5);
    endtask

    task automatic t_scattered;
        build(3, 0);
        mem[bases[1]+1] = 8'd100;
        mem[bases[2]+1] = 8'd27;
        mem[1] = 8'd3;
        exp_sum = 130;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check("R3 value addr of node 1", int'(mem_addr), bases[1] + 1);
        @(negedge clk);
        check("R4 pointer addr of node 1", int'(mem_addr), bases[1]);
        repeat (2) @(negedge clk);
        check("R6 not yet done", int'(done), 0);
        check("R7 result zero mid-walk", int'(result), 0);
        @(negedge clk);
        check("R6 done after 3 nodes", int'(done), 1);
        check("R6 scattered sum", int'($signed(result)), 130);
    endtask

    task automatic t_hold;
        int r0 = int'(result);
        mem[1] = mem[1] + 8'd1;
        repeat (10) @(negedge clk);
        check("R7 done holds", int'(done), 1);
        check("R7 result holds", int'(result), r0);
    endtask

    task automatic t_restart;
        build(6, 0);
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        repeat (5) @(negedge clk);
        mem[bases[2]+1] = mem[bases[2]+1] + 8'd7;
        exp_sum += 7;
        run_and_check("R8 restart mid-walk", 6);
        run_and_check("R8 restart from done", 6);
    endtask

    initial begin : watchdog
        repeat (150000) @(negedge clk);
        if (!finished) begin
            check("watchdog", 0, 1);
            $display("test done: total=%0d bad=%0d", total_checks, bad_checks);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
        repeat (2) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_single();
        t_scattered();
        t_hold();
        build(5, 1);
        run_and_check("R9 negative values", 5);
        build(128, 1);
        run_and_check("R9 128 nodes min", 128);
        build(128, 2);
        run_and_check("R9 128 nodes max", 128);
        for (int k = 0; k < 20; k++) begin
            int n = 1 + int'($urandom % 40);
            build(n, 0);
            run_and_check("R5 random list", n);
        end
        t_restart();
        finished = 1;
        $display("test done: total=%0d bad=%0d", total_checks, bad_checks);
        $finish;
    end
endmodule